// File: doc/BRIEF.md
# Machine Cycle Sequencer

This block sets the timing for every bus transaction of a small 8-bit CPU. A free-running phase counter splits each machine cycle into eight clock phases (0 to 7). From the phase and the current cycle kind, the block produces two timing pulses, the memory read and write strobes, the bus-drive enable for write data, and a 2-bit cycle code. It also puts the 16-bit address onto 8 shared address pins: the upper byte comes first and the lower byte follows.

The cycle kinds are fetch, execute, DMA and interrupt. A normal instruction takes one fetch and one execute cycle. When the decoder raises `long_i`, the instruction gets a second execute cycle. The DMA and interrupt requests and the four flag inputs are sampled at the timing-B phase, but only in the cycle kinds that allow it. The sampled requests then choose the cycle that follows. `wait_i` freezes the sequencer and `clr_i` sends it back to a quiet reset state.

The states are RESET, FETCH, EXEC, DMA and INT. The transitions are:
- RESET to FETCH on the first clock with clear low.
- FETCH to EXEC.
- EXEC to EXEC when a long instruction needs its second execute cycle.
- EXEC, DMA or INT to DMA when a DMA request is pending.
- EXEC or DMA to INT when an interrupt request is pending.
- EXEC, DMA or INT to FETCH otherwise.
- Any state to RESET on clear.

Top module: `mach_cycle_seq`

## Requirements
- R1: Outside reset, wait and clear, the phase advances by one each clock and wraps from 7 to 0. Any 64 consecutive free-running clocks therefore hold exactly 8 pulses of each timing pulse.
- R2: `tpa_o` is high only during phase 1 and `tpb_o` only during phase 6. Both are low in the reset state.
- R3: `ma_o` carries `addr_i[15:8]` during phases 0 and 1 and `addr_i[7:0]` during phases 2 to 7.
- R4: `mrd_n_o` is low during phases 1 to 7 of read cycles and high otherwise. Read cycles are every fetch, plus execute and DMA cycles with `wr_i`=0. Interrupt cycles never strobe.
- R5: In execute and DMA cycles with `wr_i`=1, `mwr_n_o` is low during phases 5 and 6. `bus_oe_o` is high during phases 4 to 7, so write data stays driven after the strobe ends.
- R6: A fetch is always followed by an execute cycle. If `long_i`=1 at the last clock of the first execute cycle, a second execute cycle follows. `long_i` in the second execute cycle is ignored.
- R7: `sc_o` shows 00 for fetch (and for the reset state), 01 for execute, 10 for DMA and 11 for interrupt.
- R8: Both requests are sampled at the end of phase 6 of execute and DMA cycles. Only the DMA request is sampled in interrupt cycles. After any of these cycles, a pending DMA request wins, then a pending interrupt, then fetch. DMA cycles may repeat back to back.
- R9: `flags_o` loads `flags_i` at the end of phase 6 of execute cycles only. Flag changes in other cycles leave it unchanged.
- R10: While `wait_i`=1, the phase, cycle kind, pulses, cycle code and flags hold.
- R11: While `clr_i`=1, the block is in the reset state: no strobes, no pulses, phase 0, and requests and flags cleared. On the first clock after clear falls, the block starts a fetch at phase 0.
- R12: A request that is high only away from the sampling phase has no effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to reset state |
| wait_i | input | 1 | Freeze the sequencer |
| long_i | input | 1 | Decoder asks for a second execute cycle |
| wr_i | input | 1 | Current execute/DMA cycle writes memory |
| dma_req_i | input | 1 | DMA request |
| int_req_i | input | 1 | Interrupt request |
| flags_i | input | 4 | External flag inputs |
| addr_i | input | 16 | Address of the current cycle |
| ma_o | output | 8 | Multiplexed address pins |
| tpa_o | output | 1 | Timing pulse A (phase 1) |
| tpb_o | output | 1 | Timing pulse B (phase 6) |
| mrd_n_o | output | 1 | Memory read strobe, active low |
| mwr_n_o | output | 1 | Memory write strobe, active low |
| bus_oe_o | output | 1 | Drive write data onto the bus |
| sc_o | output | 2 | Cycle code |
| flags_o | output | 4 | Flags sampled in execute cycles |

## Verification
The bench builds the block with its default values: an 8-phase cycle, a 16-bit address on 8 pins, and 4 flags. With so few phases and cycle kinds, a few thousand clocks visit every state in every phase. Arithmetic input patterns combine long instructions, read and write cycles, overlapping DMA and interrupt requests, wait stretches and clears at arbitrary phases. An independent phase and cycle model in the bench predicts every output at every clock. Directed passes count timing pulses over a long window and place request pulses away from the sampling phase.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [2:0] {
        CYC_RESET,
        CYC_FETCH,
        CYC_EXEC,
        CYC_DMA,
        CYC_INT
    } cyc_e;

    localparam logic [1:0] SC_FETCH = 2'b00;
    localparam logic [1:0] SC_EXEC  = 2'b01;
    localparam logic [1:0] SC_DMA   = 2'b10;
    localparam logic [1:0] SC_INT   = 2'b11;
endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
    parameter int CYC_LEN = 8,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            hold_i,
    output logic [PH_W-1:0] ph_o,
    output logic            last_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (restart_i) begin
            ph_q <= '0;
        end else if (!hold_i) begin
            ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
        end
    end

    assign ph_o   = ph_q;
    assign last_o = (ph_q == LAST_PH);
endmodule

// File: rtl/mcs_cycle_fsm.sv
module mcs_cycle_fsm
    import mcs_pkg::*;
#(
    parameter int PH_W      = 3,
    parameter int SAMPLE_PH = 6,
    parameter int FLAG_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wait_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic              last_i,
    input  logic              long_i,
    input  logic              dma_req_i,
    input  logic              int_req_i,
    input  logic [FLAG_W-1:0] flags_i,
    output cyc_e              state_o,
    output logic [FLAG_W-1:0] flags_o
);
    cyc_e state_q, state_d;
    logic second_q, second_d;
    logic dma_pend_q, int_pend_q;
    logic step, samp, wrap;

    assign step = !wait_i;
    assign samp = step && (ph_i == PH_W'(SAMPLE_PH));
    assign wrap = step && last_i;

    always_comb begin
        state_d  = state_q;
        second_d = second_q;
        unique case (state_q)
            CYC_RESET: state_d = CYC_FETCH;
            CYC_FETCH: begin
                if (wrap) begin
                    state_d  = CYC_EXEC;
                    second_d = 1'b0;
                end
            end
            CYC_EXEC: begin
                if (wrap) begin
                    if (long_i && !second_q) begin
                        state_d  = CYC_EXEC;
                        second_d = 1'b1;
                    end else begin
                        second_d = 1'b0;
                        state_d  = dma_pend_q ? CYC_DMA :
                                   int_pend_q ? CYC_INT : CYC_FETCH;
                    end
                end
            end
            CYC_DMA: begin
                if (wrap) begin
                    state_d = dma_pend_q ? CYC_DMA :
                              int_pend_q ? CYC_INT : CYC_FETCH;
                end
            end
            CYC_INT: begin
                if (wrap) begin
                    state_d = dma_pend_q ? CYC_DMA : CYC_FETCH;
                end
            end
            default: state_d = CYC_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CYC_RESET;
            second_q <= 1'b0;
        end else if (clr_i) begin
            state_q  <= CYC_RESET;
            second_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            second_q <= second_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_pend_q <= 1'b0;
            int_pend_q <= 1'b0;
        end else if (clr_i) begin
            dma_pend_q <= 1'b0;
            int_pend_q <= 1'b0;
        end else if (samp) begin
            if (state_q == CYC_EXEC || state_q == CYC_DMA) begin
                dma_pend_q <= dma_req_i;
                int_pend_q <= int_req_i;
            end else if (state_q == CYC_INT) begin
                dma_pend_q <= dma_req_i;
                int_pend_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end else if (samp && state_q == CYC_EXEC) begin
                flag_q <= flags_i[g];
            end
        end
        assign flags_o[g] = flag_q;
    end

    assign state_o = state_q;
endmodule

// File: rtl/mcs_strobe_gen.sv
module mcs_strobe_gen
    import mcs_pkg::*;
#(
    parameter int PH_W     = 3,
    parameter int ADDR_W   = 16,
    parameter int PIN_W    = 8,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int RD_ON_PH = 1,
    parameter int WR_ON_PH = 5,
    parameter int WR_OFF_PH = 6,
    parameter int OE_ON_PH = 4
) (
    input  cyc_e              state_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [PIN_W-1:0]  ma_o,
    output logic              tpa_o,
    output logic              tpb_o,
    output logic              mrd_n_o,
    output logic              mwr_n_o,
    output logic              bus_oe_o,
    output logic [1:0]        sc_o
);
    localparam logic [PH_W-1:0] SWAP_PH = PH_W'(TPA_PH + 1);

    logic active, rd_cyc, wr_cyc;

    always_comb begin
        active = 1'b1;
        rd_cyc = 1'b0;
        wr_cyc = 1'b0;
        sc_o   = SC_FETCH;
        unique case (state_i)
            CYC_RESET: active = 1'b0;
            CYC_FETCH: rd_cyc = 1'b1;
            CYC_EXEC: begin
                sc_o   = SC_EXEC;
                rd_cyc = !wr_i;
                wr_cyc = wr_i;
            end
            CYC_DMA: begin
                sc_o   = SC_DMA;
                rd_cyc = !wr_i;
                wr_cyc = wr_i;
            end
            CYC_INT: sc_o = SC_INT;
            default: active = 1'b0;
        endcase
    end

    assign tpa_o    = active && (ph_i == PH_W'(TPA_PH));
    assign tpb_o    = active && (ph_i == PH_W'(TPB_PH));
    assign mrd_n_o  = !(rd_cyc && (ph_i >= PH_W'(RD_ON_PH)));
    assign mwr_n_o  = !(wr_cyc && (ph_i >= PH_W'(WR_ON_PH)) && (ph_i <= PH_W'(WR_OFF_PH)));
    assign bus_oe_o = wr_cyc && (ph_i >= PH_W'(OE_ON_PH));
    assign ma_o     = (ph_i < SWAP_PH) ? addr_i[ADDR_W-1 -: PIN_W] : addr_i[PIN_W-1:0];
endmodule

// File: rtl/mach_cycle_seq.sv
module mach_cycle_seq
    import mcs_pkg::*;
#(
    parameter int CYC_LEN = 8,
    parameter int ADDR_W  = 16,
    parameter int FLAG_W  = 4,
    parameter int TPA_PH  = 1,
    parameter int TPB_PH  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                wait_i,
    input  logic                long_i,
    input  logic                wr_i,
    input  logic                dma_req_i,
    input  logic                int_req_i,
    input  logic [FLAG_W-1:0]   flags_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [ADDR_W/2-1:0] ma_o,
    output logic                tpa_o,
    output logic                tpb_o,
    output logic                mrd_n_o,
    output logic                mwr_n_o,
    output logic                bus_oe_o,
    output logic [1:0]          sc_o,
    output logic [FLAG_W-1:0]   flags_o
);
    localparam int PH_W  = $clog2(CYC_LEN);
    localparam int PIN_W = ADDR_W / 2;

    cyc_e            state_w;
    logic [PH_W-1:0] ph_w;
    logic            last_w;
    logic            restart_w;

    assign restart_w = clr_i || (state_w == CYC_RESET);

    mcs_phase_ctr #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart_w),
        .hold_i   (wait_i),
        .ph_o     (ph_w),
        .last_o   (last_w)
    );

    mcs_cycle_fsm #(.PH_W(PH_W), .SAMPLE_PH(TPB_PH), .FLAG_W(FLAG_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .wait_i   (wait_i),
        .ph_i     (ph_w),
        .last_i   (last_w),
        .long_i   (long_i),
        .dma_req_i(dma_req_i),
        .int_req_i(int_req_i),
        .flags_i  (flags_i),
        .state_o  (state_w),
        .flags_o  (flags_o)
    );

    mcs_strobe_gen #(
        .PH_W(PH_W), .ADDR_W(ADDR_W), .PIN_W(PIN_W),
        .TPA_PH(TPA_PH), .TPB_PH(TPB_PH),
        .RD_ON_PH(TPA_PH), .WR_ON_PH(TPB_PH - 1), .WR_OFF_PH(TPB_PH),
        .OE_ON_PH(TPB_PH - 2)
    ) i_strobe (
        .state_i (state_w),
        .ph_i    (ph_w),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .ma_o    (ma_o),
        .tpa_o   (tpa_o),
        .tpb_o   (tpb_o),
        .mrd_n_o (mrd_n_o),
        .mwr_n_o (mwr_n_o),
        .bus_oe_o(bus_oe_o),
        .sc_o    (sc_o)
    );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
    import mcs_pkg::*;
#(
    parameter int CYC_LEN = 8,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr_i,
    input logic            wait_i,
    input cyc_e            state,
    input logic [PH_W-1:0] ph,
    input logic            tpa,
    input logic            tpb,
    input logic            mrd_n,
    input logic            mwr_n
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wait_i && state != CYC_RESET && ph != LAST_PH) |=> ph == PH_W'($past(ph) + 1'b1)); // R1

    AST_TPA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tpa && !wait_i && !clr_i) |=> !tpa); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mrd_n && !mwr_n)); // R5

    AST_FETCH_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_FETCH && ph == LAST_PH && !wait_i && !clr_i) |=> state == CYC_EXEC); // R6

    AST_INT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_INT && ph == LAST_PH && !wait_i && !clr_i) |=> (state == CYC_DMA || state == CYC_FETCH)); // R8

    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_i && !clr_i && state != CYC_RESET) |=> (ph == $past(ph) && state == $past(state))); // R10

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mrd_n && mwr_n && !tpa && !tpb)); // R11
endmodule

bind mach_cycle_seq mcs_checker #(.CYC_LEN(CYC_LEN)) i_mcs_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .wait_i(wait_i),
    .state (state_w),
    .ph    (ph_w),
    .tpa   (tpa_o),
    .tpb   (tpb_o),
    .mrd_n (mrd_n_o),
    .mwr_n (mwr_n_o)
);

// File: tb/test_mach_cycle_seq.sv
module test_mach_cycle_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0, wait_i = 1'b0, long_i = 1'b0, wr_i = 1'b0;
    logic        dma_req_i = 1'b0, int_req_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [15:0] addr_i = '0;
    logic [7:0]  ma_o;
    logic        tpa_o, tpb_o, mrd_n_o, mwr_n_o, bus_oe_o;
    logic [1:0]  sc_o;
    logic [3:0]  flags_o;

    int checks = 0, failures = 0;

    // model: 0 reset, 1 fetch, 2 exec, 3 dma, 4 int
    int         m_st = 0, m_ph = 0;
    logic       m_second = 0, m_dma = 0, m_int = 0, m_froze = 0;
    logic [3:0] m_flags = '0;

    logic       p_tpa, p_tpb;
    logic [1:0] p_sc;
    logic [3:0] p_flags;

    always #(CLK_P/2) clk = ~clk;

    mach_cycle_seq i_mach_cycle_seq (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .wait_i(wait_i), .long_i(long_i),
        .wr_i(wr_i), .dma_req_i(dma_req_i), .int_req_i(int_req_i), .flags_i(flags_i),
        .addr_i(addr_i), .ma_o(ma_o), .tpa_o(tpa_o), .tpb_o(tpb_o), .mrd_n_o(mrd_n_o),
        .mwr_n_o(mwr_n_o), .bus_oe_o(bus_oe_o), .sc_o(sc_o), .flags_o(flags_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_ph <= 0; m_second <= 0; m_dma <= 0; m_int <= 0; m_flags <= '0; m_froze <= 0;
        end else if (clr_i) begin
            m_st <= 0; m_ph <= 0; m_second <= 0; m_dma <= 0; m_int <= 0; m_flags <= '0; m_froze <= 0;
        end else if (m_st == 0) begin
            m_st <= 1; m_ph <= 0; m_froze <= 0;
        end else if (wait_i) begin
            m_froze <= 1;
        end else begin
            m_froze <= 0;
            if (m_ph == 6) begin
                if (m_st == 2) begin m_dma <= dma_req_i; m_int <= int_req_i; m_flags <= flags_i; end
                if (m_st == 3) begin m_dma <= dma_req_i; m_int <= int_req_i; end
                if (m_st == 4) begin m_dma <= dma_req_i; m_int <= 0; end
            end
            if (m_ph == 7) begin
                m_ph <= 0;
                if (m_st == 1) begin m_st <= 2; m_second <= 0; end
                else if (m_st == 2 && long_i && !m_second) m_second <= 1;
                else begin
                    m_second <= 0;
                    if (m_dma) m_st <= 3;
                    else if (m_int && m_st != 4) m_st <= 4;
                    else m_st <= 1;
                end
            end else begin
                m_ph <= m_ph + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (st=%0d ph=%0d t=%0t)", req, what, act, exp, m_st, m_ph, $time);
        end
    endtask

    task automatic compare_all();
        logic rd, wrc;
        int   sc_e;
        string sc_req;
        rd   = (m_st == 1) || ((m_st == 2 || m_st == 3) && !wr_i);
        wrc  = (m_st == 2 || m_st == 3) && wr_i;
        sc_e = (m_st == 2) ? 1 : (m_st == 3) ? 2 : (m_st == 4) ? 3 : 0;
        sc_req = m_second ? "R6" : ((m_st == 3 || m_st == 4) ? "R8" : "R7");
        if (clr_i || m_st == 0) begin
            chk("R11", "quiet", {tpa_o, tpb_o, mrd_n_o, mwr_n_o, bus_oe_o}, 5'b00110);
        end
        chk("R2", "tpa", tpa_o, m_st != 0 && m_ph == 1);
        chk("R2", "tpb", tpb_o, m_st != 0 && m_ph == 6);
        chk("R3", "ma", ma_o, (m_ph < 2) ? addr_i[15:8] : addr_i[7:0]);
        chk("R4", "mrd_n", mrd_n_o, !(rd && m_ph >= 1));
        chk("R5", "mwr_n", mwr_n_o, !(wrc && m_ph >= 5 && m_ph <= 6));
        chk("R5", "bus_oe", bus_oe_o, wrc && m_ph >= 4);
        chk(sc_req, "sc", sc_o, sc_e);
        chk("R9", "flags", flags_o, m_flags);
        if (m_froze) begin
            chk("R10", "hold tpa", tpa_o, p_tpa);
            chk("R10", "hold tpb", tpb_o, p_tpb);
            chk("R10", "hold sc", sc_o, p_sc);
            chk("R10", "hold flags", flags_o, p_flags);
        end
        p_tpa = tpa_o; p_tpb = tpb_o; p_sc = sc_o; p_flags = flags_o;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tpa_cnt, tpb_cnt;
        #1;
        compare_all();
        #(CLK_P * 2);
        rst_n = 1'b1;
        step();
        // sweep without wait or clear
        for (int k = 0; k < 1500; k++) begin
            wr_i      = k[3] ^ k[5];
            long_i    = (k % 5) == 0;
            dma_req_i = ((k / 37) % 4) == 0;
            int_req_i = ((k / 23) % 3) == 0;
            flags_i   = k[7:4] ^ k[3:0];
            addr_i    = 16'(k * 16'h0101 + 16'h1234);
            step();
        end
        // sweep with wait and clear
        for (int k = 0; k < 2500; k++) begin
            wr_i      = k[2] ^ k[6];
            long_i    = (k % 3) == 1;
            dma_req_i = ((k / 29) % 5) == 1;
            int_req_i = ((k / 17) % 2) == 0;
            flags_i   = 4'(k * 7);
            addr_i    = 16'(k * 16'h0753);
            wait_i    = (k % 11) < 3;
            clr_i     = (k % 197) == 5;
            step();
        end
        wait_i = 0; clr_i = 0; dma_req_i = 0; int_req_i = 0; long_i = 0;
        for (int k = 0; k < 20; k++) step();
        // R1: pulse count over 64 free-running clocks
        tpa_cnt = 0; tpb_cnt = 0;
        for (int k = 0; k < 64; k++) begin
            tpa_cnt += tpa_o; tpb_cnt += tpb_o;
            step();
        end
        chk("R1", "tpa count", tpa_cnt, 8);
        chk("R1", "tpb count", tpb_cnt, 8);
        // R12: requests pulsed at phase 3 of an execute cycle are ignored
        for (int r = 0; r < 2; r++) begin
            while (!(m_st == 2 && m_ph == 3)) step();
            dma_req_i = (r == 0);
            int_req_i = (r == 1);
            step();
            dma_req_i = 0; int_req_i = 0;
            while (m_ph != 0) step();
            chk("R12", "next after off-phase request", sc_o, 0);
        end
        // R9: flags change during fetch does not load
        while (!(m_st == 1 && m_ph == 5)) step();
        flags_i = ~flags_o;
        for (int k = 0; k < 2; k++) step();
        chk("R9", "flags held in fetch", flags_o, m_flags);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule